// File: doc/BRIEF.md
# Crypto Accelerator Interrupt Controller

This block collects the interrupt sources of a multi-channel crypto accelerator and drives a single level interrupt line to the host. Every crypto channel and every execution unit reports two single-cycle pulses, one for completion and one for a fault. Four system events are also collected:
- an engine-assignment conflict, raised when a fixed assignment targets a busy execution unit;
- a transfer error acknowledge received while the block is bus master;
- a slave data parity error;
- a slave address parity error.

Each event sets its own sticky status bit. Software reads the status word, masks sources one by one, and clears bits by writing ones to a clear register. A set error bit only says that a unit failed. The cause is read from that unit's own status register, which is outside this block.

A global enable bit resets to 0 and gates every source. The per-source mask bits reset to unmasked. After reset, software can therefore mask the sources it does not want and then turn the global enable on. All registers sit behind a small word-addressed register bus with registered read data.

Top module: `cic_irq_ctrl`

## Requirements
- R1: After reset, the status word reads 0, the mask reads 0 (all sources unmasked), the control word reads 0 (global enable off), and `irq_o` is 0.
- R2: A pulse on `ch_done_i[i]` sets status bit 2*i. A pulse on `ch_err_i[i]` sets status bit 2*i+1. With the defaults these are bits 0 to 7.
- R3: A pulse on `eu_done_i[j]` sets status bit 2*NUM_CH+2*j. A pulse on `eu_err_i[j]` sets status bit 2*NUM_CH+2*j+1. With the defaults these are bits 8 to 23.
- R4: With B = 2*(NUM_CH+NUM_EU), the assignment conflict sets bit B, the transfer error sets bit B+1, the data parity error sets bit B+2, and the address parity error sets bit B+3. With the defaults these are bits 24 to 27.
- R5: A status bit stays set until it is cleared, whatever the source inputs do afterwards.
- R6: Writing the clear register (address 2) clears every status bit whose write-data bit is 1. Bits written 0 are left alone. The clear register reads 0.
- R7: If a source event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: While the global enable (control bit 0, address 3) is 0, `irq_o` is 0, even when unmasked status bits are set.
- R9: `irq_o` equals global enable AND the OR of (status AND NOT mask). It is registered, so it follows a change of status or enable one cycle later.
- R10: A mask bit (address 1) set to 1 keeps its source from raising `irq_o`. A mask write reaches `irq_o` one cycle after the write.
- R11: Bits above the last source in the status and mask words read 0. Writes to those bits, and to control bits above bit 0, are ignored.
- R12: A read (address 0 status, 1 mask, 2 clear, 3 control) returns its data on `reg_rdata_o` one cycle after the cycle in which `reg_rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_done_i | input | NUM_CH | Channel completion pulses |
| ch_err_i | input | NUM_CH | Channel fault pulses |
| eu_done_i | input | NUM_EU | Execution unit completion pulses |
| eu_err_i | input | NUM_EU | Execution unit fault pulses |
| asgn_err_i | input | 1 | Engine-assignment conflict pulse |
| xfer_err_i | input | 1 | Bus transfer error acknowledge pulse |
| dpar_err_i | input | 1 | Slave data parity error pulse |
| apar_err_i | input | 1 | Slave address parity error pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered host interrupt |

## Verification
The assertions check the following on every cycle:
- status bits stay set until cleared;
- a same-cycle event wins over a clear;
- a cleared bit with no new event drops;
- the mask holds when there is no write;
- a low global enable, or no unmasked pending source, gives a low interrupt on the next cycle;
- the reserved status bits read back as 0.

Some behaviours only the bench scenarios can show: the exact bit position of each source, that clear-register bits written 0 leave status alone, the one-cycle lag of the interrupt behind enable and mask writes, and that writes to reserved mask and control bits are dropped.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_CLR  = 2'd2,
    A_CTRL = 2'd3
  } reg_addr_e;

  function automatic int src_count(input int nch, input int neu);
    return 2 * (nch + neu) + 4;
  endfunction
endpackage

// File: rtl/cic_src_map.sv
module cic_src_map #(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 8,
  parameter int SRC_N  = 2 * (NUM_CH + NUM_EU) + 4
) (
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_err_i,
  input  logic [NUM_EU-1:0] eu_done_i,
  input  logic [NUM_EU-1:0] eu_err_i,
  input  logic              asgn_err_i,
  input  logic              xfer_err_i,
  input  logic              dpar_err_i,
  input  logic              apar_err_i,
  output logic [SRC_N-1:0]  ev_o
);
  localparam int EU_BASE  = 2 * NUM_CH;
  localparam int SYS_BASE = 2 * (NUM_CH + NUM_EU);

  // Channels: done/error pairs at the bottom of the vector
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ev_o[2*i]   = ch_done_i[i];
    assign ev_o[2*i+1] = ch_err_i[i];
  end

  // Execution units: done/error pairs above the channels
  for (genvar j = 0; j < NUM_EU; j++) begin : g_eu
    assign ev_o[EU_BASE+2*j]   = eu_done_i[j];
    assign ev_o[EU_BASE+2*j+1] = eu_err_i[j];
  end

  // System events at the top of the vector
  assign ev_o[SYS_BASE]   = asgn_err_i;
  assign ev_o[SYS_BASE+1] = xfer_err_i;
  assign ev_o[SYS_BASE+2] = dpar_err_i;
  assign ev_o[SYS_BASE+3] = apar_err_i;
endmodule

// File: rtl/cic_status_bank.sv
module cic_status_bank #(
  parameter int SRC_N = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] ev_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] st_o
);
  logic [SRC_N-1:0] st_q;

  for (genvar b = 0; b < SRC_N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          st_q[b] <= 1'b0;
      else if (ev_i[b]) st_q[b] <= 1'b1;   // event beats clear
      else if (clr_i[b]) st_q[b] <= 1'b0;
    end
  end

  assign st_o = st_q;

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i))); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & $past(ev_i)) == $past(ev_i))); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & $past(clr_i & ~ev_i)) == '0)); // R6
endmodule

// File: rtl/cic_regfile.sv
module cic_regfile
  import cic_pkg::*;
#(
  parameter int SRC_N  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [SRC_N-1:0]  st_i,
  output logic [SRC_N-1:0]  clr_o,
  output logic [SRC_N-1:0]  mask_o,
  output logic              gie_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [SRC_N-1:0]  mask_q;
  logic              gie_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] st_ext, mask_ext, ctrl_ext, rd_mux;
  logic              wr_mask, wr_ctrl, wr_clr;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata_i[DATA_W-1:SRC_N];

  assign wr_mask = reg_wr_i && (reg_addr_i == A_MASK);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_clr  = reg_wr_i && (reg_addr_i == A_CLR);

  assign clr_o = wr_clr ? reg_wdata_i[SRC_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata_i[SRC_N-1:0];
      if (wr_ctrl) gie_q  <= reg_wdata_i[0];
    end
  end

  always_comb begin
    st_ext   = '0;
    mask_ext = '0;
    ctrl_ext = '0;
    st_ext[SRC_N-1:0]   = st_i;
    mask_ext[SRC_N-1:0] = mask_q;
    ctrl_ext[0]         = gie_q;
    unique case (reg_addr_i)
      A_STAT:  rd_mux = st_ext;
      A_MASK:  rd_mux = mask_ext;
      A_CLR:   rd_mux = '0;
      default: rd_mux = ctrl_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign mask_o      = mask_q;
  assign gie_o       = gie_q;
  assign reg_rdata_o = rdata_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i != A_CTRL) |=> (rdata_q[DATA_W-1:SRC_N] == '0)); // R11
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q)); // R10
endmodule

// File: rtl/cic_irq_gen.sv
module cic_irq_gen #(
  parameter int SRC_N = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] st_i,
  input  logic [SRC_N-1:0] mask_i,
  input  logic             gie_i,
  output logic             irq_o
);
  logic irq_q;
  logic any_live;

  assign any_live = |(st_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie_i & any_live;
  end

  assign irq_o = irq_q;

  AST_GIE_OFF: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_o); // R8
  AST_NONE_LIVE: assert property (@(posedge clk) disable iff (rst)
    ((st_i & ~mask_i) == '0) |=> !irq_o); // R10
  AST_LIVE_RAISES: assert property (@(posedge clk) disable iff (rst)
    (gie_i && ((st_i & ~mask_i) != '0)) |=> irq_o); // R9
endmodule

// File: rtl/cic_irq_ctrl.sv
module cic_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_EU = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_err_i,
  input  logic [NUM_EU-1:0] eu_done_i,
  input  logic [NUM_EU-1:0] eu_err_i,
  input  logic              asgn_err_i,
  input  logic              xfer_err_i,
  input  logic              dpar_err_i,
  input  logic              apar_err_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int SRC_N = src_count(NUM_CH, NUM_EU);

  logic [SRC_N-1:0] ev, clr, st, mask;
  logic             gie;

  cic_src_map #(.NUM_CH(NUM_CH), .NUM_EU(NUM_EU), .SRC_N(SRC_N)) u_map (
    .ch_done_i (ch_done_i),
    .ch_err_i  (ch_err_i),
    .eu_done_i (eu_done_i),
    .eu_err_i  (eu_err_i),
    .asgn_err_i(asgn_err_i),
    .xfer_err_i(xfer_err_i),
    .dpar_err_i(dpar_err_i),
    .apar_err_i(apar_err_i),
    .ev_o      (ev)
  );

  cic_status_bank #(.SRC_N(SRC_N)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .ev_i (ev),
    .clr_i(clr),
    .st_o (st)
  );

  cic_regfile #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .st_i       (st),
    .clr_o      (clr),
    .mask_o     (mask),
    .gie_o      (gie),
    .reg_rdata_o(reg_rdata_o)
  );

  cic_irq_gen #(.SRC_N(SRC_N)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .st_i  (st),
    .mask_i(mask),
    .gie_i (gie),
    .irq_o (irq_o)
  );
endmodule

// File: tb/cic_irq_ctrl_test.sv
`timescale 1ns/1ps
module cic_irq_ctrl_test;
  localparam int NCH = 4;
  localparam int NEU = 8;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ch_done = '0, ch_err = '0;
  logic [NEU-1:0] eu_done = '0, eu_err = '0;
  logic asgn = 1'b0, tea = 1'b0, dpe = 1'b0, ape = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;

  always #4 clk = ~clk;

  cic_irq_ctrl #(.NUM_CH(NCH), .NUM_EU(NEU), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .ch_done_i(ch_done), .ch_err_i(ch_err),
    .eu_done_i(eu_done), .eu_err_i(eu_err),
    .asgn_err_i(asgn), .xfer_err_i(tea), .dpar_err_i(dpe), .apar_err_i(ape),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: a read sampled at a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= rd & ~rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R12 unexpected read", rdata, '0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  // Driver tasks: all start and end at a negedge
  task automatic rd_exp(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_exp(2'd0, 32'h0, "R1 status reset");
    rd_exp(2'd1, 32'h0, "R1 mask reset unmasked");
    rd_exp(2'd3, 32'h0, "R1 control reset");

    // R2 channel bits
    ch_done[1] = 1'b1; @(negedge clk); ch_done[1] = 1'b0;
    rd_exp(2'd0, 32'h0000_0004, "R2 ch1 done bit2");
    ch_err[3] = 1'b1; @(negedge clk); ch_err[3] = 1'b0;
    idle(2);
    // R8 nothing raised while global enable is off
    check("R8 irq with gie off", {31'b0, irq}, 32'h0);
    rd_exp(2'd0, 32'h0000_0084, "R2 ch3 err bit7");
    // R5 sticky after idle cycles
    idle(4);
    rd_exp(2'd0, 32'h0000_0084, "R5 sticky");

    // R6 clear with zero bits ignored
    wr_reg(2'd2, 32'h0000_0004);
    rd_exp(2'd0, 32'h0000_0080, "R6 clear bit2 only");
    rd_exp(2'd2, 32'h0, "R6 clear reads zero");

    // R3 execution unit bits
    eu_done[0] = 1'b1; eu_err[7] = 1'b1; @(negedge clk);
    eu_done[0] = 1'b0; eu_err[7] = 1'b0;
    rd_exp(2'd0, 32'h0080_0180, "R3 eu0 done bit8 eu7 err bit23");

    // R4 system bits
    asgn = 1'b1; @(negedge clk); asgn = 1'b0;
    tea = 1'b1; dpe = 1'b1; ape = 1'b1; @(negedge clk);
    tea = 1'b0; dpe = 1'b0; ape = 1'b0;
    rd_exp(2'd0, 32'h0F80_0180, "R4 system bits 24-27");

    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_exp(2'd0, 32'h0, "R6 clear all");

    // R7 event and clear in the same cycle
    ch_done[0] = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 32'h0000_0001;
    @(negedge clk);
    ch_done[0] = 1'b0; wr = 1'b0; wdata = '0;
    rd_exp(2'd0, 32'h0000_0001, "R7 event wins");

    // R9 enable on: irq one cycle after gie register
    wr_reg(2'd3, 32'h0000_0001);
    check("R9 irq lag after enable", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq raised", {31'b0, irq}, 32'h1);

    // R10 mask bit0
    wr_reg(2'd1, 32'h0000_0001);
    check("R10 irq lag after mask", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    rd_exp(2'd1, 32'h0000_0001, "R10 mask readback");

    // R11 reserved mask bits dropped
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_exp(2'd1, 32'h0FFF_FFFF, "R11 mask reserved zero");
    dpe = 1'b1; @(negedge clk); dpe = 1'b0;
    idle(2);
    check("R10 masked dpe no irq", {31'b0, irq}, 32'h0);
    wr_reg(2'd1, 32'h0);
    @(negedge clk);
    check("R9 irq after unmask", {31'b0, irq}, 32'h1);

    // R8 enable off drops irq
    wr_reg(2'd3, 32'h0);
    @(negedge clk);
    check("R8 irq dropped gie off", {31'b0, irq}, 32'h0);

    // R11 control reserved bits ignored
    wr_reg(2'd3, 32'hFFFF_FFFE);
    rd_exp(2'd3, 32'h0, "R11 ctrl reserved write ignored");
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_exp(2'd3, 32'h1, "R11 ctrl reads bit0 only");
    @(negedge clk);
    check("R9 irq back on", {31'b0, irq}, 32'h1);

    // R9 clear all sources drops irq one cycle after status
    wr_reg(2'd2, 32'hFFFF_FFFF);
    check("R9 irq lag after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);

    idle(3);
    check("R12 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule